// File: doc/BRIEF.md
# Phase-Shifted Cascaded H-Bridge PWM Generator

This block drives the switches of one phase of a cascaded H-bridge inverter built from `CELLS` series cells. With one cell the phase has three output levels, and with two cells it has five. Each cell has two legs. Leg A compares the shared reference against the cell's triangular carrier. Leg B compares the negated reference against the same carrier. The cell therefore places +V, 0 or -V across its terminals. Every cell runs the same carrier period, but each cell's carrier starts at its own point in the period. These offsets spread the switching edges of the cells apart, so that low-order carrier harmonics cancel in the summed voltage.

The reference is a signed number in carrier units and is clipped to the carrier amplitude. A `mode` input picks how the reference reaches the comparators:
- natural sampling: the live value is used;
- symmetric regular sampling: the value is held once per carrier period, at the trough;
- asymmetric regular sampling: the value is held twice per carrier period, at the trough and at the peak.

Alongside the gates, the block reports the summed phase level as a signed count from -CELLS to +CELLS. The gates and the level are registered together.

Top module: `chb_phase_pwm`

## Requirements
- R1: While `rst` is high at a clock edge, the block does the following after that edge:
  - all `gate_hi` bits are 0 and all `gate_lo` bits are 1;
  - `level` is 0;
  - every cell's carrier phase returns to its start value;
  - held references clear to 0.
- R2: At all times `gate_lo` is the bitwise inverse of `gate_hi`.
- R3: Bit 2i of `gate_hi` is leg A of cell i and bit 2i+1 is leg B. A leg is driven high when its reference is strictly greater than its carrier.
- R4: Leg A uses the effective reference r and leg B uses -r, so the cell output is A minus B.
- R5: The carrier phase counter of cell i runs over 0..2*HALF-1 and starts at i*HALF/CELLS after reset. At phase p the carrier is 2*t-HALF, where t is p for p<HALF and 2*HALF-p otherwise.
- R6: `level` is the sum over cells of (leg A minus leg B). It is registered in the same cycle as the gates, so it always equals the sum of the gate bits on the same edge.
- R7: The reference is clipped to the range -HALF..+HALF before it is used.
- R8: In mode 0 (and in the unused code 3), the clipped live reference is compared on every cycle.
- R9: In mode 1, a cell loads the reference when its phase is 0. In that cycle it uses the new value, and it holds that value for the rest of the period.
- R10: In mode 2, a cell loads the reference when its phase is 0 and when its phase is HALF. It uses the new value in each loading cycle and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; restarts all carriers together |
| mode | input | 2 | Sampling mode: 0/3 natural, 1 symmetric regular, 2 asymmetric regular |
| ref_in | input | REF_W | Signed reference in carrier units |
| gate_hi | output | 2*CELLS | Upper switch gates; bit 2i is leg A and bit 2i+1 is leg B of cell i |
| gate_lo | output | 2*CELLS | Lower switch gates, complementary to `gate_hi` |
| level | output | LW | Signed summed phase level, -CELLS..+CELLS |

## Verification
The assertions assume the following:
- `rst` is high at the first clock edge;
- `HALF` is a multiple of `CELLS`;
- the reference changes only between edges.

Under these assumptions the zero-reference rule in natural mode, the level range, and the match between `level` and the gate bits all hold. The stimulus satisfies the assumptions as follows:
- every input is driven at the falling clock edge;
- the first cycles are held in reset;
- a second reset is applied mid-run so that the carrier restart is checked again.

Reference values cover small and negative values, zero, and values far outside the carrier amplitude. The reference is also ramped on every cycle during the sampled modes, so that a value taken at the wrong phase changes the gates.

// File: rtl/chb_phase_pwm.sv
module chb_phase_pwm #(
  parameter  int CELLS = 2,
  parameter  int HALF  = 8,
  parameter  int REF_W = 8,
  localparam int LW    = $clog2(CELLS + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              mode,
  input  logic signed [REF_W-1:0] ref_in,
  output logic [2*CELLS-1:0]      gate_hi,
  output logic [2*CELLS-1:0]      gate_lo,
  output logic signed [LW-1:0]    level
);

  localparam int PER  = 2 * HALF;
  localparam int PW   = $clog2(PER);
  localparam int WS   = REF_W + 2;
  localparam int STEP = HALF / CELLS;
  localparam logic signed [WS-1:0] AMP = WS'(HALF);

  logic signed [WS-1:0] ref_w, ref_sat;
  logic [CELLS-1:0]     leg_a, leg_b;
  logic [2*CELLS-1:0]   hi_n;
  logic signed [LW-1:0] sum_n;
  wire                  use_held = (mode == 2'd1) || (mode == 2'd2);

  assign ref_w   = WS'(ref_in);
  assign ref_sat = (ref_w > AMP) ? AMP : (ref_w < -AMP) ? -AMP : ref_w;

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    logic [PW-1:0]        ph;
    logic signed [WS-1:0] held, eff, tri_v, car;
    wire at_bot = (ph == '0);
    wire at_top = (ph == PW'(HALF));
    wire samp   = (mode == 2'd1 && at_bot) || (mode == 2'd2 && (at_bot || at_top));

    always_ff @(posedge clk) begin
      if (rst) begin
        ph   <= PW'(g * STEP);
        held <= '0;
      end else begin
        ph <= (ph == PW'(PER - 1)) ? '0 : ph + 1'b1;
        if (samp) held <= ref_sat;
      end
    end

    assign eff   = use_held ? (samp ? ref_sat : held) : ref_sat;
    assign tri_v = (ph < PW'(HALF)) ? WS'(ph) : WS'(PER) - WS'(ph);
    assign car   = (tri_v <<< 1) - AMP;
    assign leg_a[g] = eff > car;
    assign leg_b[g] = -eff > car;
    assign hi_n[2*g]   = leg_a[g];
    assign hi_n[2*g+1] = leg_b[g];
  end

  always_comb begin
    sum_n = '0;
    for (int k = 0; k < CELLS; k++) begin
      if (leg_a[k]) sum_n = sum_n + LW'(1);
      if (leg_b[k]) sum_n = sum_n - LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi <= '0;
      gate_lo <= '1;
      level   <= '0;
    end else begin
      gate_hi <= hi_n;
      gate_lo <= ~hi_n;
      level   <= sum_n;
    end
  end

endmodule

// File: rtl/chb_phase_pwm_checks.sv
module chb_phase_pwm_checks #(
  parameter int CELLS = 2,
  parameter int REF_W = 8,
  parameter int LW    = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic [1:0]              mode,
  input logic signed [REF_W-1:0] ref_in,
  input logic [2*CELLS-1:0]      gate_hi,
  input logic [2*CELLS-1:0]      gate_lo,
  input logic signed [LW-1:0]    level
);

  int gate_sum;
  always_comb begin
    gate_sum = 0;
    for (int k = 0; k < CELLS; k++)
      gate_sum = gate_sum + int'(gate_hi[2*k]) - int'(gate_hi[2*k+1]);
  end

  a_r1_reset_outputs: assert property (@(posedge clk)
    $past(rst) |-> (gate_hi == '0 && gate_lo == '1 && level == '0));

  a_r2_complementary: assert property (@(posedge clk) disable iff (rst)
    gate_lo == ~gate_hi);

  a_r6_level_matches_gates: assert property (@(posedge clk) disable iff (rst)
    int'(level) == gate_sum);

  a_r6_level_range: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= CELLS && int'(level) >= -CELLS);

  a_r8_zero_ref_zero_level: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'd0 && $past(ref_in) == '0) |-> level == '0);

endmodule

bind chb_phase_pwm chb_phase_pwm_checks #(
  .CELLS(CELLS), .REF_W(REF_W), .LW(LW)
) u_checks (
  .clk(clk), .rst(rst), .mode(mode), .ref_in(ref_in),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .level(level)
);

// File: tb/chb_phase_pwm_bench.sv
module chb_phase_pwm_bench;
  localparam int C  = 2;
  localparam int H  = 8;
  localparam int RW = 8;
  localparam int LW = $clog2(C + 1) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic signed [RW-1:0] ref_in = '0;
  logic [2*C-1:0] gate_hi, gate_lo;
  logic signed [LW-1:0] level;

  always #10 clk = ~clk;

  chb_phase_pwm #(.CELLS(C), .HALF(H), .REF_W(RW)) u_chb_phase_pwm (
    .clk(clk), .rst(rst), .mode(mode), .ref_in(ref_in),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .level(level)
  );

  int checks = 0, errors = 0, cycles = 0;
  int ph[C], held[C];
  logic [2*C-1:0] exp_hi;
  int exp_lvl;
  bit have_exp = 0;
  string tag = "R8";

  function automatic int sat(int v);
    return (v > H) ? H : (v < -H) ? -H : v;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, expv, cycles);
    end
  endtask

  task automatic step(bit r, int m, int rv);
    @(negedge clk);
    if (have_exp) begin
      check(gate_hi == exp_hi, tag, int'(gate_hi), int'(exp_hi));
      check(gate_lo == ~gate_hi, "R2", int'(gate_lo), int'(~gate_hi));
      check(int'(level) == exp_lvl, "R6", int'(level), exp_lvl);
    end
    rst = r; mode = m[1:0]; ref_in = RW'(rv);
    if (r) begin
      exp_hi = '0; exp_lvl = 0;
      for (int i = 0; i < C; i++) begin ph[i] = i * H / C; held[i] = 0; end
    end else begin
      exp_lvl = 0;
      for (int i = 0; i < C; i++) begin
        int t, car, eff;
        bit smp;
        t   = (ph[i] < H) ? ph[i] : 2 * H - ph[i];
        car = 2 * t - H;
        smp = (m == 1 && ph[i] == 0) || (m == 2 && (ph[i] == 0 || ph[i] == H));
        if (m == 1 || m == 2) eff = smp ? sat(rv) : held[i];
        else eff = sat(rv);
        if (smp) held[i] = sat(rv);
        exp_hi[2*i]   = eff > car;
        exp_hi[2*i+1] = -eff > car;
        exp_lvl += int'(exp_hi[2*i]) - int'(exp_hi[2*i+1]);
        ph[i] = (ph[i] + 1) % (2 * H);
      end
    end
    have_exp = 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    for (int k = 0; k < 3; k++) step(1, 0, 0);
    @(negedge clk);
    check(gate_hi == '0 && gate_lo == '1 && level == 0, "R1", int'(gate_hi), 0);
    tag = "R5";
    for (int k = 0; k < 48; k++) step(0, 0, 3);
    tag = "R4";
    for (int k = 0; k < 32; k++) step(0, 0, -5);
    tag = "R8";
    for (int k = 0; k < 32; k++) step(0, 0, 0);
    for (int k = 0; k < 32; k++) step(0, 3, k % 17 - 8);
    tag = "R7";
    for (int k = 0; k < 32; k++) step(0, 0, 100);
    for (int k = 0; k < 32; k++) step(0, 0, -120);
    tag = "R9";
    for (int k = 0; k < 64; k++) step(0, 1, (k * 5) % 19 - 9);
    tag = "R10";
    for (int k = 0; k < 64; k++) step(0, 2, (k * 7) % 21 - 10);
    tag = "R1";
    step(1, 2, 4);
    step(1, 2, 4);
    tag = "R3";
    for (int k = 0; k < 40; k++) step(0, 0, (k % 2 == 0) ? 6 : -2);
    step(0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule